// File: doc/BRIEF.md
# Multi-Channel Serial Interrupt Aggregator

This block gathers the interrupt request lines of a group of serial channels and turns them into one level-sensitive interrupt for the host. Each serial unit holds 16 channels. Each unit has four registers: a live view of its channel requests, a channel mask whose set bits block a channel, an interrupt enable register with a single enable bit, and a command register that returns the unit's registers to their reset values. A plain prescaler register sits beside them and has no effect on the interrupt logic.

By default the block instantiates two units. Their interrupts are OR-ed together behind one card-wide enable bit. The result goes through a flop to become the single interrupt output. The block also brings out the per-channel effective pending vector (request AND NOT mask), so the host logic can see at once which channels need service.

Register access uses a simple single-cycle write strobe, with a combinational read path, on a 14-bit byte address. Address bit 13 selects the card enable register, which sits at 0x2000. When bit 13 is clear, address bit 12 selects the unit and bits 11:0 select a register inside that unit.

Top module: `intagg_top`

## Requirements
- R1: After reset every mask bit reads 1 (all channels blocked), the unit enable bits and the card enable read 0, the prescaler reads 0, and `irq_out` is 0.
- R2: Unit offset 0xC04 reads the unit's 16 raw request lines in bits 15:0, with zeros above them. A write to this offset changes nothing.
- R3: Unit offset 0xC08 is the channel mask (bits 15:0, read/write). A mask bit at 1 blocks its channel and a mask bit at 0 lets it through.
- R4: `chan_pend` equals `chan_req AND NOT mask` for every channel, in the same cycle as a change in the request or the mask.
- R5: Unit offset 0xD00 holds the unit interrupt enable in bit 20. Only that bit is stored, and the other bits read 0.
- R6: Address 0x2000 holds the card interrupt enable in bit 0. While it is 0, `irq_out` stays 0.
- R7: `irq_out` is registered. One clock after the card enable is 1 and some unit has its enable set together with at least one pending channel, `irq_out` is 1. Under any other condition it is 0 one clock later.
- R8: A write to unit offset 0xD0C with bit 0 set restores that unit's mask, enable and prescaler to their reset values at that clock edge. It does not touch the other unit or the card enable. A write with bit 0 clear has no effect.
- R9: Unit offset 0xC00 is a plain 32-bit read/write prescaler register.
- R10: Address bit 12 selects unit 0 or unit 1, and a write reaches only the selected unit. Reads from any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 14 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| chan_req | input | 32 | Raw channel request levels, 16 per unit, unit 0 in bits 15:0 |
| chan_pend | output | 32 | Effective pending (request AND NOT mask) per channel |
| irq_out | output | 1 | Registered, level-sensitive combined interrupt |

## Verification
The assertions check on every cycle that no pending bit appears without its request or while its mask bit is set. They also check that `irq_out` follows the previous cycle's enable-and-pending condition and needs the card enable. Two more hold that a mask write lands in the next cycle and that a unit-0 reset command restores its mask and enable. Only the bench scenarios can show that the reset values, the live status read and the write-ignore on the status offset are right. The same goes for isolation between the two units, command writes with bit 0 clear, prescaler storage and reads from unmapped offsets. The bench checks these through read-back against its own register model.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
   localparam int OFF_W = 12;

   localparam logic [OFF_W-1:0] OFF_PRESC = 12'hC00;
   localparam logic [OFF_W-1:0] OFF_STAT  = 12'hC04;
   localparam logic [OFF_W-1:0] OFF_MASK  = 12'hC08;
   localparam logic [OFF_W-1:0] OFF_EN    = 12'hD00;
   localparam logic [OFF_W-1:0] OFF_CMD   = 12'hD0C;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_PRESC,
      RSEL_STAT,
      RSEL_MASK,
      RSEL_EN,
      RSEL_CMD
   } reg_sel_e;

   function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
      reg_sel_e r;
      case (off)
         OFF_PRESC: r = RSEL_PRESC;
         OFF_STAT:  r = RSEL_STAT;
         OFF_MASK:  r = RSEL_MASK;
         OFF_EN:    r = RSEL_EN;
         OFF_CMD:   r = RSEL_CMD;
         default:   r = RSEL_NONE;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/intagg_unit.sv
module intagg_unit
   import intagg_pkg::*;
#(
   parameter int CH     = 16,
   parameter int DATA_W = 32,
   parameter int EN_BIT = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CH-1:0]     req,
   output logic [DATA_W-1:0] rdata,
   output logic [CH-1:0]     pend,
   output logic [CH-1:0]     mask_q,
   output logic              en_q,
   output logic              unit_irq
);
   localparam logic [CH-1:0]     MASK_RST  = '1;
   localparam logic [DATA_W-1:0] PRESC_RST = '0;

   logic [DATA_W-1:0] presc_q;
   reg_sel_e          rsel;
   logic              wr_hit;

   assign rsel   = decode_off(off);
   assign wr_hit = wr && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= MASK_RST;
         en_q    <= 1'b0;
         presc_q <= PRESC_RST;
      end else if (wr_hit) begin
         case (rsel)
            RSEL_CMD: begin
               if (wdata[0]) begin
                  mask_q  <= MASK_RST;
                  en_q    <= 1'b0;
                  presc_q <= PRESC_RST;
               end
            end
            RSEL_PRESC: presc_q <= wdata;
            RSEL_MASK:  mask_q  <= wdata[CH-1:0];
            RSEL_EN:    en_q    <= wdata[EN_BIT];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (rsel)
         RSEL_PRESC: rdata = presc_q;
         RSEL_STAT:  rdata[CH-1:0] = req;
         RSEL_MASK:  rdata[CH-1:0] = mask_q;
         RSEL_EN:    rdata[EN_BIT] = en_q;
         default:    rdata = '0;
      endcase
   end

   assign pend     = req & ~mask_q;
   assign unit_irq = en_q && (|pend);
endmodule

// File: rtl/intagg_card.sv
module intagg_card #(
   parameter int NUM_UNITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 sel,
   input  logic                 wbit,
   input  logic [NUM_UNITS-1:0] unit_irq,
   output logic                 card_en,
   output logic                 irq_out
);
   logic any_unit;

   assign any_unit = |unit_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_en <= 1'b0;
         irq_out <= 1'b0;
      end else begin
         if (wr && sel) card_en <= wbit;
         irq_out <= card_en && any_unit;
      end
   end
endmodule

// File: rtl/intagg_top.sv
module intagg_top
   import intagg_pkg::*;
#(
   parameter int NUM_UNITS = 2,
   parameter int CH        = 16,
   parameter int DATA_W    = 32,
   parameter int EN_BIT    = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [13:0]             bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [NUM_UNITS*CH-1:0] chan_req,
   output logic [NUM_UNITS*CH-1:0] chan_pend,
   output logic                    irq_out
);
   localparam int NCH    = NUM_UNITS * CH;
   localparam int UIDX_W = 1;

   generate
      if (NUM_UNITS < 1 || NUM_UNITS > 2) begin : g_bad_units
         $error("intagg_top: NUM_UNITS must be 1 or 2");
      end
      if (DATA_W < CH || DATA_W <= EN_BIT) begin : g_bad_width
         $error("intagg_top: DATA_W too narrow for CH or EN_BIT");
      end
   endgenerate

   logic                card_hit;
   logic                unit_hit;
   logic [UIDX_W-1:0]   uidx;
   logic [OFF_W-1:0]    off;
   logic [NUM_UNITS-1:0] sel_u;
   logic [NUM_UNITS-1:0] unit_irq;
   logic [NUM_UNITS-1:0] en_all;
   logic [NCH-1:0]       mask_all;
   logic                 card_en;
   logic [DATA_W-1:0]    unit_rd [NUM_UNITS];

   assign off      = bus_addr[OFF_W-1:0];
   assign card_hit = bus_addr[13] && (bus_addr[12:0] == 13'h0);

   generate
      if (NUM_UNITS == 2) begin : g_sel_two
         assign uidx     = bus_addr[12];
         assign unit_hit = !bus_addr[13];
      end else begin : g_sel_one
         assign uidx     = 1'b0;
         assign unit_hit = !bus_addr[13] && !bus_addr[12];
      end
   endgenerate

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign sel_u[u] = unit_hit && (uidx == UIDX_W'(u));

      intagg_unit #(
         .CH    (CH),
         .DATA_W(DATA_W),
         .EN_BIT(EN_BIT)
      ) u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (bus_wr),
         .sel     (sel_u[u]),
         .off     (off),
         .wdata   (bus_wdata),
         .req     (chan_req[u*CH +: CH]),
         .rdata   (unit_rd[u]),
         .pend    (chan_pend[u*CH +: CH]),
         .mask_q  (mask_all[u*CH +: CH]),
         .en_q    (en_all[u]),
         .unit_irq(unit_irq[u])
      );
   end

   intagg_card #(
      .NUM_UNITS(NUM_UNITS)
   ) u_card (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .sel     (card_hit),
      .wbit    (bus_wdata[0]),
      .unit_irq(unit_irq),
      .card_en (card_en),
      .irq_out (irq_out)
   );

   always_comb begin
      bus_rdata = '0;
      if (card_hit) begin
         bus_rdata[0] = card_en;
      end else begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (sel_u[u]) bus_rdata = unit_rd[u];
         end
      end
   end
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
   parameter int NUM_UNITS = 2,
   parameter int CH        = 16,
   parameter int DATA_W    = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_wr,
   input logic [13:0]             bus_addr,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [NUM_UNITS*CH-1:0] chan_req,
   input logic [NUM_UNITS*CH-1:0] chan_pend,
   input logic                    irq_out,
   input logic                    card_en,
   input logic [NUM_UNITS*CH-1:0] mask_all,
   input logic [NUM_UNITS-1:0]    en_all
);
   logic [NUM_UNITS-1:0] unit_live;
   logic                 want_irq;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_live
      assign unit_live[u] = en_all[u] && (|chan_pend[u*CH +: CH]);
   end
   assign want_irq = card_en && (|unit_live);

   AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_pend & ~chan_req) == '0); // R4
   AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_pend & mask_all) == '0); // R3
   AST_IRQ_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(card_en)); // R6
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(want_irq)); // R7
   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 14'h0C08) |=> (mask_all[CH-1:0] == $past(bus_wdata[CH-1:0]))); // R3
   AST_CMD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 14'h0D0C && bus_wdata[0]) |=> (mask_all[CH-1:0] == '1 && !en_all[0])); // R8
endmodule

bind intagg_top intagg_chk #(
   .NUM_UNITS(NUM_UNITS),
   .CH       (CH),
   .DATA_W   (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .chan_req (chan_req),
   .chan_pend(chan_pend),
   .irq_out  (irq_out),
   .card_en  (card_en),
   .mask_all (mask_all),
   .en_all   (en_all)
);

// File: tb/intagg_top_test.sv
`timescale 1ns/1ps
module intagg_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] chan_req = '0;
   logic [31:0] chan_pend;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] m_mask [2];
   logic        m_en   [2];
   logic [31:0] m_presc[2];
   logic        m_card;

   always #4 clk = ~clk;

   intagg_top uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .chan_req (chan_req),
      .chan_pend(chan_pend),
      .irq_out  (irq_out)
   );

   function automatic logic [13:0] ua(input int u, input logic [11:0] off);
      return {1'b0, u[0], off};
   endfunction

   function automatic logic [31:0] exp_pend();
      return chan_req & ~{m_mask[1], m_mask[0]};
   endfunction

   function automatic logic exp_irq();
      logic [31:0] p;
      p = exp_pend();
      return m_card && ((m_en[0] && |p[15:0]) || (m_en[1] && |p[31:16]));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [13:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic model_wr(input logic [13:0] a, input logic [31:0] d);
      wr(a, d);
      if (a == 14'h2000) m_card = d[0];
      else if (!a[13]) begin
         case (a[11:0])
            12'hC00: m_presc[a[12]] = d;
            12'hC08: m_mask[a[12]]  = d[15:0];
            12'hD00: m_en[a[12]]    = d[20];
            12'hD0C: if (d[0]) begin
               m_mask[a[12]] = 16'hFFFF; m_en[a[12]] = 1'b0; m_presc[a[12]] = '0;
            end
            default: ;
         endcase
      end
   endtask

   task automatic settle_check_irq(input string tag);
      @(negedge clk);
      @(negedge clk);
      check({tag, " pend"}, chan_pend, exp_pend());
      check({tag, " irq"}, {31'b0, irq_out}, {31'b0, exp_irq()});
   endtask

   task automatic check_regs();
      logic [31:0] d;
      for (int u = 0; u < 2; u++) begin
         rd(ua(u, 12'hC08), d); check("R3 mask readback", d, {16'h0, m_mask[u]});
         rd(ua(u, 12'hD00), d); check("R5 enable readback", d, {11'h0, m_en[u], 20'h0});
         rd(ua(u, 12'hC00), d); check("R9 prescaler readback", d, m_presc[u]);
         rd(ua(u, 12'hC04), d); check("R2 status readback", d, {16'h0, chan_req[u*16 +: 16]});
      end
      rd(14'h2000, d); check("R6 card enable readback", d, {31'b0, m_card});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int seed;
      seed = $urandom(32'd20240611);
      for (int u = 0; u < 2; u++) begin
         m_mask[u] = 16'hFFFF; m_en[u] = 1'b0; m_presc[u] = '0;
      end
      m_card = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
      check_regs();
      chan_req = 32'hFFFF_FFFF;
      settle_check_irq("R1 all masked");

      // R6 card gate and R7 latency
      model_wr(ua(0, 12'hD00), 32'h0010_0000);
      model_wr(ua(0, 12'hC08), 32'h0000_FFFE);
      settle_check_irq("R6 card disabled");
      @(negedge clk) bus_addr = 14'h2000; bus_wdata = 32'h1; bus_wr = 1'b1; m_card = 1'b1;
      @(negedge clk) bus_wr = 1'b0;
      check("R7 irq one cycle after enable write", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      check("R7 irq after register delay", {31'b0, irq_out}, 32'h1);
      chan_req[0] = 1'b0;
      #1 check("R4 pend follows request same cycle", chan_pend, exp_pend());
      settle_check_irq("R7 request dropped");

      // R2 status write ignored
      chan_req = 32'h1234_5678;
      model_wr(ua(0, 12'hC04), 32'hFFFF_FFFF);
      check_regs();

      // R10 unit isolation and unmapped reads
      model_wr(ua(1, 12'hC08), 32'h0000_00F0);
      rd(ua(0, 12'hC08), d); check("R10 unit0 mask untouched", d, {16'h0, m_mask[0]});
      rd(ua(1, 12'hC10), d); check("R10 unmapped read", d, 32'h0);
      rd(14'h2004, d);       check("R10 unmapped card read", d, 32'h0);

      // R8 command behaviour
      model_wr(ua(0, 12'hC00), 32'hA5A5_0101);
      model_wr(ua(0, 12'hD0C), 32'h0000_0002);
      check_regs();
      model_wr(ua(1, 12'hD00), 32'h0010_0000);
      model_wr(ua(0, 12'hD0C), 32'h0000_0001);
      rd(ua(1, 12'hD00), d); check("R8 other unit enable kept", d, 32'h0010_0000);
      check_regs();
      settle_check_irq("R8 after command");

      // random phase
      for (int i = 0; i < 400; i++) begin
         int op, u;
         logic [31:0] v;
         op = $urandom % 7; u = $urandom % 2; v = $urandom;
         @(negedge clk) chan_req = $urandom & $urandom;
         case (op)
            0: model_wr(ua(u, 12'hC08), v & $urandom);
            1: model_wr(ua(u, 12'hD00), v);
            2: model_wr(14'h2000, (i % 5 == 0) ? {v[31:1], 1'b0} : {v[31:1], 1'b1});
            3: model_wr(ua(u, 12'hD0C), (i % 9 == 0) ? v : {v[31:1], 1'b0});
            4: model_wr(ua(u, 12'hC00), v);
            5: model_wr(ua(u, 12'hC04), v);
            default: ;
         endcase
         settle_check_irq("R7 random");
         if (i % 8 == 0) check_regs();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule